// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans one asynchronous pad input before the GPIO input data and interrupt logic see it. The pad level first passes through a two-flop synchronizer. A stability filter then holds the cleaned output at its old level until the synchronized input has sat at a new level for a programmable number of clocks. Shorter pulses are discarded.

Two 4-bit fields set the window. The scale field S picks a power-of-two prescale of the core clock, so one tick lasts 2^S clocks. The length field C says how many of those ticks the new level must last. The window is C × 2^S clocks, which ranges from 1 clock up to 15 × 32768 clocks. A length of zero bypasses the filter: the synchronized level is passed straight through with no added delay. The GPIO controller decodes both fields from its configuration register and delivers them as plain inputs.

The prescaler and the stability counter both restart whenever the synchronized input equals the filtered output. Each new candidate level therefore gets a full and deterministic window, measured from the clock in which the mismatch first appears.

Top module: `glitch_filter`

## Requirements
- R1: While reset is asserted and directly after it is released, `filtOut` is 0.
- R2: The pad input reaches the synchronized level after exactly two rising clock edges. In bypass, `filtOut` shows a pad change in the cycle after the second rising edge following the change.
- R3: A length field of 0 bypasses the filter for any scale field value. A pad pulse lasting one clock then still appears on `filtOut`.
- R4: With length C ≥ 1 and scale S, the pad may hold a new level for N = C·2^S rising edges. `filtOut` then takes that level after exactly N+2 rising edges from the first edge that samples the change.
- R5: A scale field of 0 gives a tick every clock, so the window is C clocks.
- R6: A pad pulse lasting N−1 clocks leaves `filtOut` unchanged.
- R7: Rejected pulses do not accumulate. After the input returns to the output level, a later change needs a full fresh window.
- R8: Scale 4 with length 9 gives a window of exactly 144 clocks.
- R9: The largest windows (scale 10 and above) work without counter overflow. Scale 10 with length 15 gives 15360 clocks.
- R10: `filtOut` never changes while the synchronized input equals it.
- R11: Rising and falling transitions are filtered identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| padIn | input | 1 | Raw asynchronous pad level |
| lenField | input | 4 | Window length C in prescaled ticks; 0 bypasses the filter |
| scaleField | input | 4 | Prescale exponent S; one tick lasts 2^S clocks |
| filtOut | output | 1 | Filtered, synchronized level |

## Verification
A prescaler or stability counter that is left stale shows up as a window that is too short or too long. It appears at `filtOut` on the first accepted transition after the fault, so the bench fixes the exact output cycle of every transition. A counter that is not cleared after a rejected glitch makes the next near-window pulse pass, so pulses of N−1 clocks follow each other back to back. A wrong held level is visible at once, because the output is compared on every cycle against the level the bench predicts.

// File: rtl/glitch_filter_pkg.sv
package glitch_filter_pkg;
  // strobes from the control to the datapath, one cycle wide
  typedef struct packed {
    logic bypass;   // length field zero: pass synchronized level through
    logic restart;  // input matches output: clear prescaler and tick count
    logic tick;     // prescaled tick while a mismatch is pending
    logic commit;   // last tick of the window: take the new level
  } filtStrobe_t;
endpackage

// File: rtl/glitch_filter_ctl.sv
module glitch_filter_ctl
  import glitch_filter_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int SCALE_W = 4,
  localparam int PRE_W = (1 << SCALE_W) - 1
) (
  input  logic [LEN_W-1:0]   lenField,
  input  logic [SCALE_W-1:0] scaleField,
  input  logic               mismatch,
  input  logic [PRE_W-1:0]   preCnt,
  input  logic [LEN_W-1:0]   tickCnt,
  output filtStrobe_t        strobe
);
  logic [PRE_W-1:0] tickMask;
  logic             lastTick;

  always_comb begin
    tickMask = {PRE_W{1'b1}} >> (PRE_W - int'(scaleField));
    lastTick = ({1'b0, tickCnt} + 1'b1) >= {1'b0, lenField};
    strobe.bypass  = (lenField == '0);
    strobe.restart = !mismatch || strobe.bypass;
    strobe.tick    = !strobe.restart && (preCnt >= tickMask);
    strobe.commit  = strobe.tick && lastTick;
  end
endmodule

// File: rtl/glitch_filter_dp.sv
module glitch_filter_dp
  import glitch_filter_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int SCALE_W = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PRE_W = (1 << SCALE_W) - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             padIn,
  input  filtStrobe_t      strobe,
  output logic             syncLvl,
  output logic             mismatch,
  output logic [PRE_W-1:0] preCnt,
  output logic [LEN_W-1:0] tickCnt,
  output logic             filtOut
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   heldLvl;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= padIn;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[g] <= 1'b0;
          else       syncChain[g] <= syncChain[g-1];
      end
    end
  endgenerate

  assign syncLvl  = syncChain[SYNC_STAGES-1];
  assign mismatch = syncLvl != heldLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldLvl <= 1'b0;
      preCnt  <= '0;
      tickCnt <= '0;
    end else begin
      if (strobe.bypass || strobe.commit) heldLvl <= syncLvl;
      if (strobe.restart || strobe.tick)  preCnt  <= '0;
      else                                preCnt  <= preCnt + 1'b1;
      if (strobe.restart || strobe.commit) tickCnt <= '0;
      else if (strobe.tick)                tickCnt <= tickCnt + 1'b1;
    end
  end

  assign filtOut = strobe.bypass ? syncLvl : heldLvl;
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
  import glitch_filter_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               padIn,
  input  logic [LEN_W-1:0]   lenField,
  input  logic [SCALE_W-1:0] scaleField,
  output logic               filtOut
);
  localparam int PRE_W = (1 << SCALE_W) - 1;

  filtStrobe_t      strobe;
  logic             syncLvl;
  logic             mismatch;
  logic [PRE_W-1:0] preCnt;
  logic [LEN_W-1:0] tickCnt;

  glitch_filter_ctl #(.LEN_W(LEN_W), .SCALE_W(SCALE_W)) uCtl (
    .lenField(lenField), .scaleField(scaleField), .mismatch(mismatch),
    .preCnt(preCnt), .tickCnt(tickCnt), .strobe(strobe)
  );

  glitch_filter_dp #(.LEN_W(LEN_W), .SCALE_W(SCALE_W), .SYNC_STAGES(2)) uDp (
    .clk(clk), .rstN(rstN), .padIn(padIn), .strobe(strobe),
    .syncLvl(syncLvl), .mismatch(mismatch), .preCnt(preCnt),
    .tickCnt(tickCnt), .filtOut(filtOut)
  );
endmodule

// File: rtl/glitch_filter_chk.sv
module glitch_filter_chk #(
  parameter int LEN_W = 4,
  parameter int SCALE_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               padIn,
  input logic [LEN_W-1:0]   lenField,
  input logic [SCALE_W-1:0] scaleField,
  input logic               syncLvl,
  input logic               filtOut
);
  localparam int RUN_W = 24;

  logic [RUN_W-1:0] runLen;
  logic [RUN_W-1:0] window;
  logic [LEN_W-1:0] prevLen;
  logic [SCALE_W-1:0] prevScale;
  logic [1:0] sinceRst;
  logic fieldsSteady;

  assign window = RUN_W'(lenField) << scaleField;
  assign fieldsSteady = (prevLen == lenField) && (prevScale == scaleField);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0; prevLen <= '0; prevScale <= '0; sinceRst <= '0;
    end else begin
      prevLen <= lenField;
      prevScale <= scaleField;
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
      if (syncLvl == filtOut || !fieldsSteady) runLen <= '0;
      else if (runLen != '1) runLen <= runLen + 1'b1;
    end
  end

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> syncLvl == $past(padIn, 2)); // R2

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (lenField == '0) |-> filtOut == syncLvl); // R3

  AST_NO_MOVE_WHEN_MATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (syncLvl == filtOut && lenField != '0) |=> (lenField == '0 || $stable(filtOut))); // R10

  AST_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (lenField != '0 && $past(lenField) != '0 && fieldsSteady && filtOut != $past(filtOut))
      |-> ($past(runLen) + 1'b1) >= window); // R4

  AST_TAKES_SYNC_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (lenField != '0 && $past(lenField) != '0 && filtOut != $past(filtOut))
      |-> filtOut == $past(syncLvl)); // R11
endmodule

bind glitch_filter glitch_filter_chk #(.LEN_W(LEN_W), .SCALE_W(SCALE_W)) uChk (
  .clk(clk), .rstN(rstN), .padIn(padIn), .lenField(lenField),
  .scaleField(scaleField), .syncLvl(syncLvl), .filtOut(filtOut)
);

// File: tb/glitch_filter_test.sv
module glitch_filter_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic padIn = 1'b0;
  logic [3:0] lenF = 4'd0;
  logic [3:0] scaleF = 4'd0;
  logic filtOut;

  typedef struct { int at; logic val; } expItem_t;
  expItem_t expQ[$];

  int cyc = 0;
  int checkCnt = 0;
  int failCnt = 0;
  logic modelOut = 1'b0;
  logic expOut = 1'b0;
  logic running = 1'b0;
  string curTag = "R1";

  glitch_filter uut (
    .clk(clk), .rstN(rstN), .padIn(padIn), .lenField(lenF),
    .scaleField(scaleF), .filtOut(filtOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops predicted transitions and compares every cycle
  always @(negedge clk) begin
    if (running) begin
      while (expQ.size() > 0 && expQ[0].at <= cyc) begin
        expOut = expQ[0].val;
        void'(expQ.pop_front());
      end
      checkCnt++;
      if (filtOut !== expOut) begin
        failCnt++;
        $display("FAIL %s: filtOut=%0b expected %0b at cycle %0d", curTag, filtOut, expOut, cyc);
      end
    end
  end

  // driver: holds a pad level for len clocks and predicts the output
  task automatic driveLvl(input logic lvl, input int len, input string tag);
    int n;
    n = (lenF == 0) ? 0 : (int'(lenF) << scaleF);
    @(negedge clk);
    curTag = tag;
    padIn = lvl;
    if (lvl != modelOut && (lenF == 0 || len >= n)) begin
      modelOut = lvl;
      expQ.push_back('{at: cyc + 2 + n, val: lvl});
    end
    repeat (len - 1) @(negedge clk);
  endtask

  task automatic setFields(input int c, input int s);
    @(negedge clk);
    lenF = 4'(c);
    scaleF = 4'(s);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    lenF = 4'd9; scaleF = 4'd4; padIn = 1'b1;
    repeat (4) @(negedge clk);
    checkCnt++; // R1 during reset
    if (filtOut !== 1'b0) begin
      failCnt++;
      $display("FAIL R1: filtOut=%0b expected 0 in reset", filtOut);
    end
    padIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    curTag = "R1";
    repeat (3) @(negedge clk);

    // bypass with both fields zero: R2, R3
    setFields(0, 0);
    driveLvl(1'b1, 5, "R2");
    driveLvl(1'b0, 1, "R3");
    driveLvl(1'b1, 5, "R3");
    setFields(0, 7);
    driveLvl(1'b0, 1, "R3");
    driveLvl(1'b1, 6, "R3");

    // scale 0: tick every clock, window 3 (R5, R4, R6, R10)
    setFields(3, 0);
    driveLvl(1'b0, 3, "R5");
    driveLvl(1'b0, 4, "R4");
    driveLvl(1'b1, 2, "R6");
    driveLvl(1'b0, 6, "R10");
    driveLvl(1'b1, 10, "R4");

    // window 20: glitch rejection and restart (R6, R7, R11)
    setFields(5, 2);
    driveLvl(1'b0, 19, "R6");
    driveLvl(1'b1, 4, "R7");
    driveLvl(1'b0, 19, "R7");
    driveLvl(1'b1, 3, "R7");
    driveLvl(1'b0, 20, "R4");
    driveLvl(1'b0, 5, "R4");
    driveLvl(1'b1, 30, "R11");

    // common setting: window 144 (R8)
    setFields(9, 4);
    driveLvl(1'b0, 143, "R8");
    driveLvl(1'b1, 5, "R8");
    driveLvl(1'b0, 144, "R8");
    driveLvl(1'b0, 5, "R8");
    driveLvl(1'b1, 200, "R8");

    // long window 15360 (R9)
    setFields(15, 10);
    driveLvl(1'b0, 15359, "R9");
    driveLvl(1'b1, 10, "R9");
    driveLvl(1'b0, 15360, "R9");
    driveLvl(1'b0, 5, "R9");
    driveLvl(1'b1, 15400, "R9");

    repeat (20) @(negedge clk);
    checkCnt++;
    if (expQ.size() != 0) begin
      failCnt++;
      $display("FAIL R4: pending transitions=%0d expected 0", expQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule